// File: doc/BRIEF.md
# Opcode-Selected Integer ALU

This block is the arithmetic and logic unit of a small teaching processor's datapath. It takes two operands of a configurable width and a four-bit operation code, and returns one result word. It computes sums and differences, bitwise AND, OR and XOR, logical shifts in both directions by a variable amount, and two compare operations that return 0 or 1. The operation codes form a sparse map: code 2 and codes 0xA through 0xF are unused and return zero.

The unit is purely combinational. The control path chooses what feeds each operand outside the block. With the program counter on operand A, the constant 4 on operand B and the add code, the unit computes the next sequential address. With an immediate on operand B, the same add and subtract codes serve immediate arithmetic.

Top module: `opsel_alu`

## Requirements
- R1: Code 0x0 gives y = a + b modulo 2^WIDTH.
- R2: Code 0x1 gives y = a - b modulo 2^WIDTH.
- R3: Code 0x3 gives the bitwise AND of a and b, code 0x4 the bitwise OR, and code 0x5 the bitwise XOR.
- R4: Code 0x6 shifts a right logically by the shift amount and fills the vacated upper bits with zeros.
- R5: Code 0x7 shifts a left by the shift amount and fills the vacated lower bits with zeros.
- R6: The shift amount is the low log2(WIDTH) bits of b. The upper bits of b have no effect on either shift.
- R7: Code 0x8 returns 1 when a is less than b, both read as two's-complement signed values, and returns 0 otherwise.
- R8: Code 0x9 returns 1 when a equals b and returns 0 otherwise.
- R9: Code 0x2 and codes 0xA through 0xF return y = 0 for any operands.
- R10: With WIDTH = 32, a = PC, b = 4 and code 0x0, y equals PC + 4 and wraps past 0xFFFFFFFF.
- R11: y follows the inputs with no clock and holds no state, so a result depends only on the present inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| a_i | input | WIDTH | Operand A (the value shifted by the shift codes) |
| b_i | input | WIDTH | Operand B (its low bits give the shift amount) |
| y_o | output | WIDTH | Result word |

## Verification
The assertions check algebraic relations between the result and the operands whenever the inputs change. These relations are: the sum and difference can be undone, the AND result is contained in both operands, the OR result contains both operands, XOR cancels, a right shift never increases the value, the compare codes give a value of 0 or 1, and the unused codes give zero. Exact shift values, the masking of the shift amount, the signed ordering at the sign boundary and the wrap of the program counter increment are shown only by the bench. The bench sweeps every code and operand pair on a narrow instance and runs directed cases on a 32-bit instance.

// File: rtl/opsel_alu_pkg.sv
// Package: opsel_alu_pkg
// Holds the operation-code values shared by the ALU and its checker.
// The code values are fixed. The unused codes are not listed here.
package opsel_alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OPC_ADD = 4'h0,
        OPC_SUB = 4'h1,
        OPC_AND = 4'h3,
        OPC_OR  = 4'h4,
        OPC_XOR = 4'h5,
        OPC_SHR = 4'h6,
        OPC_SHL = 4'h7,
        OPC_SLT = 4'h8,
        OPC_SEQ = 4'h9
    } alu_opc_e;

endpackage

// File: rtl/opsel_alu_addsub.sv
// Module: opsel_alu_addsub
// Uses one carry chain for both add and subtract. Subtraction inverts b
// and adds a carry-in of one. Also produces the signed less-than result,
// taken from the difference with a correction when the operand signs
// differ, and an equality result that does not depend on the adder.
// Assumes: the sign-based result is meaningful only while sub_i is high.
module opsel_alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             lt_o,
    output logic             eq_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;

    // Invert operand B for subtraction and add the carry-in.
    always_comb begin
        b_eff = b_i ^ {WIDTH{sub_i}};
        sum_o = a_i + b_eff + {{(WIDTH-1){1'b0}}, sub_i};
    end

    // Signed compare: when the signs differ, a is less exactly when a is negative.
    always_comb begin
        if (a_i[MSB] != b_i[MSB]) begin
            lt_o = a_i[MSB];
        end else begin
            lt_o = sum_o[MSB];
        end
    end

    // Equality, taken directly from the operands.
    always_comb begin
        eq_o = (a_i == b_i);
    end

endmodule

// File: rtl/opsel_alu_logic.sv
// Module: opsel_alu_logic
// Computes the three bitwise results in parallel. The top-level
// multiplexer picks one of them.
module opsel_alu_logic #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] and_o,
    output logic [WIDTH-1:0] or_o,
    output logic [WIDTH-1:0] xor_o
);
    // Compute the three bitwise results.
    always_comb begin
        and_o = a_i & b_i;
        or_o  = a_i | b_i;
        xor_o = a_i ^ b_i;
    end

endmodule

// File: rtl/opsel_alu_shift.sv
// Module: opsel_alu_shift
// Logarithmic shifter. Stage k moves the data by 2^k positions when
// bit k of the amount is set. One chain shifts right and one shifts
// left, and both fill with zeros.
// Assumes: WIDTH is a power of two, at least 2. The amount is SHW bits wide.
module opsel_alu_shift #(
    parameter int WIDTH = 32,
    parameter int SHW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [SHW-1:0]   amt_i,
    output logic [WIDTH-1:0] shr_o,
    output logic [WIDTH-1:0] shl_o
);
    logic [WIDTH-1:0] rstage [0:SHW];
    logic [WIDTH-1:0] lstage [0:SHW];

    assign rstage[0] = a_i;
    assign lstage[0] = a_i;

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int DIST = 1 << k;
        // Each stage either passes its input or shifts it by 2^k positions.
        assign rstage[k+1] = amt_i[k] ? (rstage[k] >> DIST) : rstage[k];
        assign lstage[k+1] = amt_i[k] ? (lstage[k] << DIST) : lstage[k];
    end

    assign shr_o = rstage[SHW];
    assign shl_o = lstage[SHW];

endmodule

// File: rtl/opsel_alu.sv
// Module: opsel_alu (top)
// Combinational ALU selected by a sparse 4-bit operation code. Code 2
// and codes 0xA-0xF are unused and return zero. The compare codes
// return 0 or 1 in bit 0.
// Assumes: the operand routing (PC, immediates) is done outside this block.
// WIDTH is a power of two, at least 2. There is no clock and no reset.
module opsel_alu
    import opsel_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] y_o
);
    localparam int SHW = $clog2(WIDTH);

    logic             sub_sel;
    logic [WIDTH-1:0] arith_res;
    logic             lt_res;
    logic             eq_res;
    logic [WIDTH-1:0] and_res;
    logic [WIDTH-1:0] or_res;
    logic [WIDTH-1:0] xor_res;
    logic [WIDTH-1:0] shr_res;
    logic [WIDTH-1:0] shl_res;

    // The carry chain adds only for the add code. Subtract and the compares use the difference.
    always_comb begin
        sub_sel = (op_i != OPC_ADD);
    end

    opsel_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a_i   (a_i),
        .b_i   (b_i),
        .sub_i (sub_sel),
        .sum_o (arith_res),
        .lt_o  (lt_res),
        .eq_o  (eq_res)
    );

    opsel_alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a_i   (a_i),
        .b_i   (b_i),
        .and_o (and_res),
        .or_o  (or_res),
        .xor_o (xor_res)
    );

    opsel_alu_shift #(.WIDTH(WIDTH), .SHW(SHW)) u_shift (
        .a_i   (a_i),
        .amt_i (b_i[SHW-1:0]),
        .shr_o (shr_res),
        .shl_o (shl_res)
    );

    // Result select. Unlisted codes give zero.
    always_comb begin
        case (op_i)
            OPC_ADD, OPC_SUB: y_o = arith_res;
            OPC_AND:          y_o = and_res;
            OPC_OR:           y_o = or_res;
            OPC_XOR:          y_o = xor_res;
            OPC_SHR:          y_o = shr_res;
            OPC_SHL:          y_o = shl_res;
            OPC_SLT:          y_o = {{(WIDTH-1){1'b0}}, lt_res};
            OPC_SEQ:          y_o = {{(WIDTH-1){1'b0}}, eq_res};
            default:          y_o = '0;
        endcase
    end

endmodule

// File: rtl/opsel_alu_chk.sv
// Module: opsel_alu_chk
// Checker bound to opsel_alu. It checks algebraic relations between the
// operands and the result with immediate assertions, evaluated each time
// the inputs or the result change.
// Assumes: the same WIDTH as the bound instance.
module opsel_alu_chk #(
    parameter int WIDTH = 32
) (
    input logic [3:0]       op_i,
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [WIDTH-1:0] y_o
);
    localparam int SHW = $clog2(WIDTH);

    logic [WIDTH-1:0] undo_add;
    logic [WIDTH-1:0] undo_sub;
    logic [SHW-1:0]   amt;

    // Derive the inverse results and the shift amount.
    always_comb begin
        undo_add = y_o - b_i;
        undo_sub = y_o + b_i;
        amt      = b_i[SHW-1:0];
    end

    // Check each operation against its algebraic property.
    always_comb begin
        a_r1_add_inverse:  assert (op_i != 4'h0 || undo_add == a_i);
        a_r2_sub_inverse:  assert (op_i != 4'h1 || undo_sub == a_i);
        a_r3_and_subset:   assert (op_i != 4'h3 || ((y_o & ~a_i) == '0 && (y_o & ~b_i) == '0));
        a_r3_or_superset:  assert (op_i != 4'h4 || ((y_o & a_i) == a_i && (y_o & b_i) == b_i));
        a_r3_xor_cancel:   assert (op_i != 4'h5 || (y_o ^ b_i) == a_i);
        a_r4_shr_shrinks:  assert (op_i != 4'h6 || y_o <= a_i);
        a_r5_shl_lowzero:  assert (op_i != 4'h7 || amt == '0 || y_o[0] == 1'b0);
        a_r7_slt_boolean:  assert (op_i != 4'h8 || (y_o[WIDTH-1:1] == '0 && (a_i != b_i || y_o[0] == 1'b0)));
        a_r8_seq_boolean:  assert (op_i != 4'h9 || (y_o[WIDTH-1:1] == '0 && y_o[0] == ($countones(a_i ^ b_i) == 0)));
        a_r9_unused_zero:  assert (!(op_i == 4'h2 || op_i >= 4'hA) || y_o == '0);
    end

endmodule

bind opsel_alu opsel_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .op_i (op_i),
    .a_i  (a_i),
    .b_i  (b_i),
    .y_o  (y_o)
);

// File: tb/opsel_alu_tb.sv
// Bench for opsel_alu. A 4-bit instance gets an exhaustive sweep of all
// codes and operand pairs. A 32-bit instance gets directed cases.
// Inputs change on the falling edge and are sampled 1 ns later.
module opsel_alu_tb;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic [3:0]  op4;
    logic [3:0]  a4, b4;
    logic [3:0]  y4;
    logic [3:0]  op32;
    logic [31:0] a32, b32;
    logic [31:0] y32;

    opsel_alu #(.WIDTH(4)) u_dut (
        .op_i (op4), .a_i (a4), .b_i (b4), .y_o (y4)
    );

    opsel_alu #(.WIDTH(32)) u_dut_w32 (
        .op_i (op32), .a_i (a32), .b_i (b32), .y_o (y32)
    );

    // Record one comparison.
    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Reference result for the 4-bit instance, computed arithmetically.
    function automatic int model4(int op, int a, int b);
        int sa, sb, s;
        sa = (a >= 8) ? a - 16 : a;
        sb = (b >= 8) ? b - 16 : b;
        s  = b % 4;
        case (op)
            0: return (a + b) % 16;
            1: return (a - b + 16) % 16;
            3: return a & b;
            4: return a | b;
            5: return a ^ b;
            6: return a / (2 ** s);
            7: return (a * (2 ** s)) % 16;
            8: return (sa < sb) ? 1 : 0;
            9: return (a == b) ? 1 : 0;
            default: return 0;
        endcase
    endfunction

    // Requirement tag for each code of the sweep.
    function automatic string tag_of(int op);
        case (op)
            0: return "R1";
            1: return "R2";
            3, 4, 5: return "R3";
            6: return "R4/R6";
            7: return "R5/R6";
            8: return "R7";
            9: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Apply one input set to the wide instance and check the result.
    task automatic wide(input string req, input int op, input longint a, input longint b, input longint exp);
        @(negedge clk);
        op32 = op[3:0]; a32 = a[31:0]; b32 = b[31:0];
        #1;
        check(req, longint'(y32), exp);
    endtask

    initial begin
        op4 = '0; a4 = '0; b4 = '0;
        op32 = '0; a32 = '0; b32 = '0;
        // Idle state: zero operands with the add code give zero.
        @(negedge clk); #1;
        check("R1 idle", longint'(y4), 0);
        check("R1 idle", longint'(y32), 0);

        // Exhaustive sweep of the 4-bit instance.
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    @(negedge clk);
                    op4 = op[3:0]; a4 = a[3:0]; b4 = b[3:0];
                    #1;
                    check(tag_of(op), longint'(y4), longint'(model4(op, a, b)));
                end
            end
        end

        // R11: the result changes in the same time step as the inputs, without waiting for a clock edge.
        @(negedge clk);
        op4 = 4'h0; a4 = 4'd3; b4 = 4'd4; #1;
        a4 = 4'd5; #1;
        check("R11", longint'(y4), 9);

        // Directed 32-bit cases.
        wide("R10 pc+4",       0, 64'h0000_1000, 4, 64'h0000_1004);
        wide("R10 pc wrap",    0, 64'hFFFF_FFFC, 4, 64'h0000_0000);
        wide("R2 borrow",      1, 0, 1, 64'hFFFF_FFFF);
        wide("R1 carry",       0, 64'h8000_0000, 64'h8000_0001, 1);
        wide("R3 and",         3, 64'hF0F0_1234, 64'h0FF0_FFFF, 64'h00F0_1234);
        wide("R3 or",          4, 64'hF000_0001, 64'h0000_0F00, 64'hF000_0F01);
        wide("R3 xor",         5, 64'hAAAA_5555, 64'hFFFF_0000, 64'h5555_5555);
        wide("R4 shr zero",    6, 64'h8000_0000, 31, 1);
        wide("R5 shl",         7, 1, 31, 64'h8000_0000);
        wide("R6 shr mask",    6, 64'hF000_0000, 64'h0000_0124, 64'h0F00_0000);
        wide("R6 shl mask",    7, 64'h0000_000F, 64'hFFFF_FFE0, 64'h0000_000F);
        wide("R7 neg<pos",     8, 64'h8000_0000, 64'h7FFF_FFFF, 1);
        wide("R7 pos<neg",     8, 64'h7FFF_FFFF, 64'h8000_0000, 0);
        wide("R7 -1<0",        8, 64'hFFFF_FFFF, 0, 1);
        wide("R7 equal",       8, 5, 5, 0);
        wide("R8 equal",       9, 64'hDEAD_BEEF, 64'hDEAD_BEEF, 1);
        wide("R8 differ",      9, 64'hDEAD_BEEF, 64'hDEAD_BEEE, 0);
        wide("R9 code2",       2, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 0);
        wide("R9 codeF",      15, 64'h1234_5678, 64'h0000_0001, 0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R11: watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule